// File: doc/BRIEF.md
# Seven-to-one display link serializer

The block accepts one parallel video word per pixel clock and sends it over four serial lanes. Each word has eighteen colour bits (six each of red, green and blue) and three timing bits (line sync, frame sync, data enable). These 21 bits are split across three data lanes, seven bits per lane per pixel period. A fourth lane forwards a clock at the same bit rate. A bit clock running at seven times the pixel clock is supplied from outside; the block contains no PLL and no analog driver.

A strobe-select input chooses the pixel-clock edge on which the word is captured. An active-low power-down input holds the whole block in reset and disables all four lane enables, which model the tri-state condition. If the pixel clock stops while the block is powered, all four lanes are driven low with their enables kept on. They return to normal only after the pixel clock has come back and a fresh word has been loaded at a frame boundary.

Top module: `dispLinkSerializer`

## Requirements
- R1: Each word present at a capture edge is serialized exactly once. Words appear on the lanes in the order they were captured, one 7-bit frame per pixel period.
- R2: Within a frame each lane sends its group most significant bit first, one bit per bit-clock cycle. Data lane 0 carries {red[5:0], green[0]}. Data lane 1 carries {green[5:1], blue[1:0]}. Data lane 2 carries {blue[5:2], lineSync, frameSync, dataEn}.
- R3: Whenever the lanes are active, the clock lane repeats the 7-bit pattern 1100011 (first bit sent on the left). Its first bit coincides with the first bit of each data frame.
- R4: With strobeRise high the word is captured on the rising pixel-clock edge. With it low the word is captured on the falling edge.
- R5: While pwrDnN is low, all four bits of laneOe are 0, all lane outputs are 0, and all state is held in reset. While pwrDnN is high, all four bits of laneOe are 1.
- R6: After pwrDnN is released, all lanes stay low until the first complete frame has been loaded. Output then starts on the first bit of that frame, with the clock lane high.
- R7: If no rising pixel-clock edge is seen for LOSS_LIMIT (16) bit-clock cycles, all four lanes are driven low while laneOe stays all ones. Before that limit is reached, the lanes keep running.
- R8: After a clock loss, output resumes only after RESUME_EDGES (2) consecutive rising pixel edges. It resumes at a frame boundary, with a word captured after the clock returned; a single edge does not re-enable the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock, seven times the pixel rate |
| pixClk | input | 1 | Pixel clock |
| pwrDnN | input | 1 | Active-low power-down and reset |
| strobeRise | input | 1 | Capture-edge select: 1 rising, 0 falling |
| red | input | 6 | Red colour bits |
| green | input | 6 | Green colour bits |
| blue | input | 6 | Blue colour bits |
| lineSync | input | 1 | Line sync |
| frameSync | input | 1 | Frame sync |
| dataEn | input | 1 | Data enable |
| dataLane | output | 3 | Serial data lanes |
| clkLane | output | 1 | Serial forwarded-clock lane |
| laneOe | output | 4 | Per-lane drive enable; {clock, data2, data1, data0} |

## Verification
The stimulus drives each intended word just before the selected capture edge and its inverse just after it. A design that sampled on the wrong edge would therefore send only inverted words, which a scoreboard decoding frames from the clock-lane pattern catches at once. A scrambled lane map or a reversed bit order fails the same comparison. The bench stops the pixel clock to check that the lanes keep running at first and are then forced low with enables still on. On restart it checks that a single edge does not re-enable them, and that the first frame seen carries a new word rather than the stale one left in the holding register. Power-down is applied while the pixel clock keeps running, to show that nothing leaks onto the lanes, and the stretch of low output between release and the first loaded frame is checked.

// File: rtl/dtxPkg.sv
package dtxPkg;
  localparam int LANE_BITS  = 7;
  localparam int DATA_LANES = 3;
  localparam int COLOR_BITS = 6;
  localparam int WORD_BITS  = LANE_BITS * DATA_LANES;
  localparam logic [LANE_BITS-1:0] CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic [COLOR_BITS-1:0] red;
    logic [COLOR_BITS-1:0] green;
    logic [COLOR_BITS-1:0] blue;
    logic                  lineSync;
    logic                  frameSync;
    logic                  dataEn;
  } pixWord_t;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic copyWord;   // synchronized word is new: take it into the holding register
    logic loadFrame;  // last bit slot: reload the shift registers
    logic lanesOn;    // lanes may show the shift-register contents
  } txStrobe_t;
endpackage

// File: rtl/dtxCapture.sv
module dtxCapture
  import dtxPkg::*;
(
  input  logic     pixClk,
  input  logic     pwrDnN,
  input  logic     strobeRise,
  input  pixWord_t pixIn,
  output pixWord_t capWord,
  output logic     capToggle
);
  pixWord_t riseWord, fallWord;
  logic     riseTgl, fallTgl;

  always_ff @(posedge pixClk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      riseWord <= '0;
      riseTgl  <= 1'b0;
    end else begin
      riseWord <= pixIn;
      riseTgl  <= ~riseTgl;
    end
  end

  always_ff @(negedge pixClk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      fallWord <= '0;
      fallTgl  <= 1'b0;
    end else begin
      fallWord <= pixIn;
      fallTgl  <= ~fallTgl;
    end
  end

  // the edge choice is static between power-downs
  assign capWord   = strobeRise ? riseWord : fallWord;
  assign capToggle = strobeRise ? riseTgl  : fallTgl;
endmodule

// File: rtl/dtxCtrl.sv
module dtxCtrl
  import dtxPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int LOSS_LIMIT   = 16,
  parameter int RESUME_EDGES = 2
) (
  input  logic      bitClk,
  input  logic      pwrDnN,
  input  logic      pixClk,
  input  logic      capToggle,
  output txStrobe_t strobe
);
  localparam int SLOT_W = $clog2(LANE_BITS);
  localparam int IDLE_W = $clog2(LOSS_LIMIT);
  localparam int EDGE_W = $clog2(RESUME_EDGES + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANE_BITS - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(LOSS_LIMIT - 1);
  localparam logic [EDGE_W-1:0] EDGE_MAX  = EDGE_W'(RESUME_EDGES - 1);

  logic [SYNC_STAGES:0] pixSync, tglSync;
  logic [SLOT_W-1:0]    slotCnt;
  logic [IDLE_W-1:0]    idleCnt;
  logic [EDGE_W-1:0]    edgeCnt;
  logic                 lost, haveWord, running;
  logic                 pixEdge, newWord, lastSlot;

  always_ff @(posedge bitClk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      pixSync <= '0;
      tglSync <= '0;
    end else begin
      pixSync <= {pixSync[SYNC_STAGES-1:0], pixClk};
      tglSync <= {tglSync[SYNC_STAGES-1:0], capToggle};
    end
  end

  assign pixEdge  = pixSync[SYNC_STAGES-1] & ~pixSync[SYNC_STAGES];
  assign newWord  = tglSync[SYNC_STAGES-1] ^ tglSync[SYNC_STAGES];
  assign lastSlot = (slotCnt == LAST_SLOT);

  // free-running bit-slot counter fixes the frame phase
  always_ff @(posedge bitClk or negedge pwrDnN) begin
    if (!pwrDnN)       slotCnt <= '0;
    else if (lastSlot) slotCnt <= '0;
    else               slotCnt <= slotCnt + 1'b1;
  end

  // pixel-clock watchdog; starts in the lost state
  always_ff @(posedge bitClk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      idleCnt <= '0;
      edgeCnt <= '0;
      lost    <= 1'b1;
    end else if (pixEdge) begin
      idleCnt <= '0;
      if (lost) begin
        if (edgeCnt == EDGE_MAX) begin
          lost    <= 1'b0;
          edgeCnt <= '0;
        end else begin
          edgeCnt <= edgeCnt + 1'b1;
        end
      end
    end else if (idleCnt == IDLE_MAX) begin
      lost    <= 1'b1;
      edgeCnt <= '0;
    end else begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // output runs only once a fresh word sits in the holding register
  always_ff @(posedge bitClk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      haveWord <= 1'b0;
      running  <= 1'b0;
    end else if (lost) begin
      haveWord <= 1'b0;
      running  <= 1'b0;
    end else begin
      if (newWord)              haveWord <= 1'b1;
      if (lastSlot && haveWord) running  <= 1'b1;
    end
  end

  assign strobe.copyWord  = newWord;
  assign strobe.loadFrame = lastSlot;
  assign strobe.lanesOn   = running & ~lost;
endmodule

// File: rtl/dtxShift.sv
module dtxShift
  import dtxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  bitClk,
  input  logic                  pwrDnN,
  input  pixWord_t              capWord,
  input  txStrobe_t             strobe,
  output logic [DATA_LANES-1:0] dataLane,
  output logic                  clkLane
);
  pixWord_t [SYNC_STAGES-1:0] wordPipe;
  pixWord_t                   holdWord;
  logic [WORD_BITS-1:0]       laneWord;
  logic [LANE_BITS-1:0]       clkShift;

  always_ff @(posedge bitClk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      wordPipe <= '0;
      holdWord <= '0;
    end else begin
      wordPipe[0] <= capWord;
      for (int s = 1; s < SYNC_STAGES; s++) wordPipe[s] <= wordPipe[s-1];
      if (strobe.copyWord) holdWord <= wordPipe[SYNC_STAGES-1];
    end
  end

  // lane groups, lane 0 in the low slice
  assign laneWord = {holdWord.blue[5:2], holdWord.lineSync, holdWord.frameSync, holdWord.dataEn,
                     holdWord.green[5:1], holdWord.blue[1:0],
                     holdWord.red, holdWord.green[0]};

  for (genvar l = 0; l < DATA_LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] laneShift;
    always_ff @(posedge bitClk or negedge pwrDnN) begin
      if (!pwrDnN)              laneShift <= '0;
      else if (strobe.loadFrame) laneShift <= laneWord[l*LANE_BITS +: LANE_BITS];
      else                      laneShift <= {laneShift[LANE_BITS-2:0], 1'b0};
    end
    assign dataLane[l] = laneShift[LANE_BITS-1] & strobe.lanesOn;
  end

  always_ff @(posedge bitClk or negedge pwrDnN) begin
    if (!pwrDnN)              clkShift <= '0;
    else if (strobe.loadFrame) clkShift <= CLK_PATTERN;
    else                      clkShift <= {clkShift[LANE_BITS-2:0], 1'b0};
  end

  assign clkLane = clkShift[LANE_BITS-1] & strobe.lanesOn;
endmodule

// File: rtl/dispLinkSerializer.sv
module dispLinkSerializer
  import dtxPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int LOSS_LIMIT   = 16,
  parameter int RESUME_EDGES = 2
) (
  input  logic       bitClk,
  input  logic       pixClk,
  input  logic       pwrDnN,
  input  logic       strobeRise,
  input  logic [5:0] red,
  input  logic [5:0] green,
  input  logic [5:0] blue,
  input  logic       lineSync,
  input  logic       frameSync,
  input  logic       dataEn,
  output logic [2:0] dataLane,
  output logic       clkLane,
  output logic [3:0] laneOe
);
  pixWord_t  pixIn, capWord;
  logic      capToggle;
  txStrobe_t strobe;

  assign pixIn.red       = red;
  assign pixIn.green     = green;
  assign pixIn.blue      = blue;
  assign pixIn.lineSync  = lineSync;
  assign pixIn.frameSync = frameSync;
  assign pixIn.dataEn    = dataEn;

  dtxCapture u_cap (
    .pixClk(pixClk), .pwrDnN(pwrDnN), .strobeRise(strobeRise),
    .pixIn(pixIn), .capWord(capWord), .capToggle(capToggle)
  );

  dtxCtrl #(
    .SYNC_STAGES(SYNC_STAGES), .LOSS_LIMIT(LOSS_LIMIT), .RESUME_EDGES(RESUME_EDGES)
  ) u_ctrl (
    .bitClk(bitClk), .pwrDnN(pwrDnN), .pixClk(pixClk),
    .capToggle(capToggle), .strobe(strobe)
  );

  dtxShift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .bitClk(bitClk), .pwrDnN(pwrDnN), .capWord(capWord),
    .strobe(strobe), .dataLane(dataLane), .clkLane(clkLane)
  );

  assign laneOe = {4{pwrDnN}};
endmodule

// File: rtl/dtxChk.sv
module dtxChk (
  input logic       bitClk,
  input logic       pwrDnN,
  input logic [2:0] dataLane,
  input logic       clkLane,
  input logic [3:0] laneOe,
  input logic       lanesOn
);
  logic [2:0] onCnt;

  always_ff @(posedge bitClk or negedge pwrDnN) begin
    if (!pwrDnN)           onCnt <= '0;
    else if (!lanesOn)     onCnt <= '0;
    else if (onCnt != 3'd7) onCnt <= onCnt + 3'd1;
  end

  // R5
  always @(negedge bitClk) begin
    if (!pwrDnN) begin
      pd_quiet_chk: assert (laneOe == 4'b0000 && dataLane == 3'b000 && clkLane == 1'b0)
        else $error("lanes active during power-down");
    end
  end

  // R5
  oe_on_chk: assert property (@(posedge bitClk) disable iff (!pwrDnN)
    laneOe == 4'b1111);

  // R7
  forced_low_chk: assert property (@(posedge bitClk) disable iff (!pwrDnN)
    !lanesOn |-> (dataLane == 3'b000 && !clkLane));

  // R3
  clk_period_chk: assert property (@(posedge bitClk) disable iff (!pwrDnN)
    (lanesOn && onCnt == 3'd7) |-> clkLane == $past(clkLane, 7));

  // R6
  start_bit_chk: assert property (@(posedge bitClk) disable iff (!pwrDnN)
    $rose(lanesOn) |-> clkLane);
endmodule

bind dispLinkSerializer dtxChk u_chk (
  .bitClk(bitClk), .pwrDnN(pwrDnN), .dataLane(dataLane),
  .clkLane(clkLane), .laneOe(laneOe), .lanesOn(strobe.lanesOn)
);

// File: tb/dispLinkSerializer_tb.sv
module dispLinkSerializer_tb;
  localparam int BIT_PERIOD = 10;
  localparam int PIX_HALF   = BIT_PERIOD * 7 / 2;

  logic       bitClk = 1'b0, pixClk = 1'b0, pixRun = 1'b0;
  logic       pwrDnN = 1'b1, strobeRise = 1'b0;
  logic [5:0] red = '0, green = '0, blue = '0;
  logic       lineSync = 1'b0, frameSync = 1'b0, dataEn = 1'b0;
  logic [2:0] dataLane;
  logic       clkLane;
  logic [3:0] laneOe;

  int  vecCnt = 0, failCnt = 0, matchCnt = 0, frameCnt = 0;
  bit  monOn = 0, synced = 0, draining = 0, done = 0;
  logic [20:0] expQ[$];
  logic [6:0]  clkH = '0, l0H = '0, l1H = '0, l2H = '0;

  dispLinkSerializer u_dut (
    .bitClk(bitClk), .pixClk(pixClk), .pwrDnN(pwrDnN), .strobeRise(strobeRise),
    .red(red), .green(green), .blue(blue), .lineSync(lineSync),
    .frameSync(frameSync), .dataEn(dataEn),
    .dataLane(dataLane), .clkLane(clkLane), .laneOe(laneOe)
  );

  always #(BIT_PERIOD/2) bitClk = ~bitClk;
  initial begin
    #2;
    forever begin
      #(PIX_HALF);
      if (pixRun) pixClk = ~pixClk;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    vecCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected serial image {lane2, lane1, lane0} of a word {r,g,b,hs,vs,de}
  function automatic logic [20:0] toFrame(logic [20:0] w);
    logic [5:0] r, g, b;
    r = w[20:15]; g = w[14:9]; b = w[8:3];
    return {b[5:2], w[2], w[1], w[0], g[5:1], b[1:0], r, g[0]};
  endfunction

  task automatic setWord(logic [20:0] w);
    {red, green, blue, lineSync, frameSync, dataEn} = w;
  endtask

  // driver: intended word before the chosen edge, its inverse after it
  task automatic driveWords(int n, int seed);
    for (int i = 0; i < n; i++) begin
      automatic logic [20:0] w = 21'(i * 40503 + seed * 977) ^ 21'h15A5A;
      if (strobeRise) @(negedge pixClk); else @(posedge pixClk);
      #1 setWord(w);
      expQ.push_back(toFrame(w));
      if (strobeRise) @(posedge pixClk); else @(negedge pixClk);
      #1 setWord(~w);
    end
  endtask

  // monitor: frames are framed by the clock-lane pattern
  always @(negedge bitClk) begin
    clkH = {clkH[5:0], clkLane};
    l0H  = {l0H[5:0], dataLane[0]};
    l1H  = {l1H[5:0], dataLane[1]};
    l2H  = {l2H[5:0], dataLane[2]};
    if (monOn && laneOe == 4'hF && clkH == 7'b1100011) begin
      automatic logic [20:0] got = {l2H, l1H, l0H};
      frameCnt++;
      if (!synced) begin
        automatic bit found = 0;
        for (int k = 0; k < 8 && expQ.size() > 0 && !found; k++) begin
          if (expQ[0] == got) found = 1;
          else void'(expQ.pop_front());
        end
        check(found, "R1", "first frame matches no queued word", int'(got), 0);
        if (found) begin
          void'(expQ.pop_front());
          synced = 1;
          matchCnt++;
        end
      end else if (expQ.size() == 0) begin
        if (!draining) check(0, "R1", "frame with empty queue", int'(got), 0);
      end else begin
        automatic logic [20:0] exp = expQ.pop_front();
        check(got == exp, "R2", "lane bits", int'(got), int'(exp));
        if (got == exp) matchCnt++;
      end
    end
  end

  task automatic runPhase(int n, int seed, string tag);
    expQ.delete();
    synced = 0; draining = 0; matchCnt = 0; frameCnt = 0; monOn = 1;
    driveWords(n, seed);
    draining = 1;
    repeat (30) @(negedge bitClk);
    monOn = 0;
    check(expQ.size() == 0, "R1", "words never sent", expQ.size(), 0);
    check(frameCnt > 0, "R3", "no clock-lane frame seen", frameCnt, n);
    check(matchCnt >= n - 8, tag, "matched frames", matchCnt, n);
  endtask

  task automatic pdCheck();
    repeat (10) @(negedge bitClk);
    // R5: quiet while the pixel clock still runs
    check(laneOe == 4'h0 && dataLane == 3'b000 && clkLane == 1'b0, "R5",
          "power-down outputs", {laneOe, dataLane, clkLane}, 0);
  endtask

  task automatic releaseCheck();
    automatic bit quiet = 1;
    @(negedge bitClk);
    #2 pwrDnN = 1'b1;
    repeat (6) begin
      @(negedge bitClk);
      if (laneOe != 4'hF || dataLane != 3'b000 || clkLane) quiet = 0;
    end
    // R6: enabled but low before the first frame
    check(quiet, "R6", "lanes before first frame", {laneOe, dataLane, clkLane}, 8'hF0);
  endtask

  initial begin
    automatic bit early = 0, lowAll = 1;
    #1 pwrDnN = 1'b0;
    pixRun = 1'b1;
    strobeRise = 1'b0;
    pdCheck();
    releaseCheck();
    runPhase(40, 1, "R4");          // falling-edge capture

    @(negedge bitClk) #2 pwrDnN = 1'b0;
    pdCheck();
    strobeRise = 1'b1;
    releaseCheck();
    runPhase(40, 2, "R4");          // rising-edge capture

    // clock loss (R7)
    pixRun = 1'b0;
    repeat (10) begin
      @(negedge bitClk);
      if (clkLane) early = 1;
    end
    check(early, "R7", "lanes forced before limit", 0, 1);
    repeat (30) @(negedge bitClk);
    repeat (14) begin
      @(negedge bitClk);
      if (laneOe != 4'hF || dataLane != 3'b000 || clkLane) lowAll = 0;
    end
    check(lowAll, "R7", "lanes during clock loss", {laneOe, dataLane, clkLane}, 8'hF0);

    // restart (R8): one edge must not re-enable
    pixRun = 1'b1;
    lowAll = 1;
    repeat (8) begin
      @(negedge bitClk);
      if (dataLane != 3'b000 || clkLane) lowAll = 0;
    end
    check(lowAll, "R8", "lanes right after restart", {dataLane, clkLane}, 0);
    runPhase(40, 3, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    #(BIT_PERIOD * 200000);
    if (!done) begin
      failCnt++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end
endmodule